// File: doc/BRIEF.md
# Handshake-Gated Registered Word Transmitter

This block takes one 64-bit word from an upstream source whenever a valid/ready handshake is seen and presents that word on a registered output one clock later. A completion pulse comes from its own flop, so the pulse and the new word appear in the same cycle. A downstream consumer can therefore latch `data_out` on any cycle where `tx_done` is high, without extra alignment logic.

A one-bit controller sequences each transfer. In the waiting state it watches for `valid` and `ready` to be high together. When that happens it raises an internal load strobe and moves to a sending state for exactly one cycle, then goes back to waiting no matter what the inputs do. The block therefore accepts at most one word every two cycles. A handshake seen while the controller is in the sending state is dropped. The controller state is brought out on a port so that it can be observed.

Top module: `hsx_tx_stage`

## Requirements
- R1: A word is taken only on a clock edge where `valid` and `ready` are both 1 and the controller is in the waiting state (`state_o` = 0). Any other combination moves no data.
- R2: The word path is 64 bits wide. After a word is taken, `data_out` equals the `data_in` value from the handshake cycle, starting in the cycle right after the handshake.
- R3: `tx_done` is 1 in exactly the cycle where `data_out` first shows a newly taken word, never one cycle earlier. It is a single-cycle pulse for each word.
- R4: Reset is synchronous and active-high. After a clock edge with `rst` = 1, `state_o` = 0, `data_out` = 0 and `tx_done` = 0.
- R5: In the waiting state, while either `valid` or `ready` is 0, the controller stays in the waiting state.
- R6: In the waiting state with `valid` and `ready` both 1, the controller is in the sending state (`state_o` = 1) on the next cycle.
- R7: From the sending state the controller returns to the waiting state on the next cycle unconditionally. A handshake seen while in the sending state is ignored: `data_out` keeps its value and `tx_done` stays 0 in the following cycle.
- R8: Between transfers, `data_out` holds the last word taken, or zero if no word has been taken since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Source has a word on `data_in` |
| ready | input | 1 | Transfer permitted |
| data_in | input | 64 | Word offered by the source |
| data_out | output | 64 | Registered word, held between transfers |
| tx_done | output | 1 | One-cycle pulse aligned with a new `data_out` |
| state_o | output | 1 | Controller state: 0 waiting, 1 sending |

## Verification
A controller stuck in the sending state, or one that fails to leave it, shows up on the first cycle after a handshake. `state_o` reads wrong, and a handshake held high is then either accepted twice in a row or never accepted. A load strobe that is not gated by the state makes `data_out` change with no matching pulse in the cycle after a handshake made during the sending state. A done flag taken from the strobe without its register shows up one cycle early relative to the new word. A per-cycle scoreboard, built from an independent model of the two-state sequence, compares all three outputs on every cycle, so each of these faults is reported within one cycle of the stimulus that exposes it.

// File: rtl/hsx_pkg.sv
package hsx_pkg;

    // Default width of one transferred word.
    localparam int unsigned HSX_WORD_W = 64;

    // Controller states: one bit, waiting = 0, sending = 1.
    typedef enum logic {
        HSX_WAIT = 1'b0,
        HSX_SEND = 1'b1
    } hsx_state_e;

    // Decision made in one cycle by the controller.
    typedef struct packed {
        hsx_state_e next_state;
        logic       load;
    } hsx_step_t;

    // Next-state and load strobe for a given state and handshake pair.
    function automatic hsx_step_t hsx_step(input hsx_state_e cur,
                                           input logic valid_i,
                                           input logic ready_i);
        hsx_step_t s;
        s.load       = 1'b0;
        s.next_state = HSX_WAIT;
        unique case (cur)
            HSX_WAIT: begin
                if (valid_i && ready_i) begin
                    s.load       = 1'b1;
                    s.next_state = HSX_SEND;
                end
            end
            HSX_SEND: begin
                s.next_state = HSX_WAIT;
            end
            default: begin
                s.next_state = HSX_WAIT;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/hsx_ctrl.sv
module hsx_ctrl
    import hsx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    input  logic       ready,
    output hsx_state_e state,
    output logic       load
);

    hsx_state_e state_q;
    hsx_step_t  step;

    always_comb begin
        step = hsx_step(state_q, valid, ready);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HSX_WAIT;
        end else begin
            state_q <= step.next_state;
        end
    end

    assign state = state_q;
    assign load  = step.load;

endmodule

// File: rtl/hsx_word_reg.sv
module hsx_word_reg #(
    parameter int unsigned WORD_W = hsx_pkg::HSX_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_out
);

    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= word_in;
        end
    end

    assign word_out = word_q;

endmodule

// File: rtl/hsx_done_reg.sv
module hsx_done_reg (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic done
);

    logic sel_bit;
    logic done_q;

    // Select stage: strobe picks a one, otherwise a zero.
    always_comb begin
        sel_bit = load ? 1'b1 : 1'b0;
    end

    // Delay stage: lines the flag up with the registered word.
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else begin
            done_q <= sel_bit;
        end
    end

    assign done = done_q;

endmodule

// File: rtl/hsx_tx_stage.sv
module hsx_tx_stage
    import hsx_pkg::*;
#(
    parameter int unsigned WORD_W = HSX_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              ready,
    input  logic [WORD_W-1:0] data_in,
    output logic [WORD_W-1:0] data_out,
    output logic              tx_done,
    output logic              state_o
);

    hsx_state_e ctrl_state;
    logic       load_strobe;

    hsx_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .valid (valid),
        .ready (ready),
        .state (ctrl_state),
        .load  (load_strobe)
    );

    hsx_word_reg #(
        .WORD_W (WORD_W)
    ) u_word (
        .clk      (clk),
        .rst      (rst),
        .load     (load_strobe),
        .word_in  (data_in),
        .word_out (data_out)
    );

    hsx_done_reg u_done (
        .clk  (clk),
        .rst  (rst),
        .load (load_strobe),
        .done (tx_done)
    );

    assign state_o = ctrl_state;

endmodule

// File: rtl/hsx_tx_stage_chk.sv
module hsx_tx_stage_chk #(
    parameter int unsigned WORD_W = hsx_pkg::HSX_WORD_W
) (
    input logic              clk,
    input logic              rst,
    input logic              valid,
    input logic              ready,
    input logic [WORD_W-1:0] data_in,
    input logic [WORD_W-1:0] data_out,
    input logic              tx_done,
    input logic              state_o
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (state_o == 1'b0 && data_out == '0 && !tx_done)); // R4

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_o == 1'b0 && !(valid && ready)) |=> (state_o == 1'b0 && !tx_done)); // R5

    AST_ENTER_SEND: assert property (@(posedge clk) disable iff (rst)
        (state_o == 1'b0 && valid && ready) |=> (state_o == 1'b1)); // R6

    AST_WORD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (state_o == 1'b0 && valid && ready) |=> (data_out == $past(data_in) && tx_done)); // R2

    AST_SEND_RETURN: assert property (@(posedge clk) disable iff (rst)
        (state_o == 1'b1) |=> (state_o == 1'b0 && !tx_done)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done); // R3

    AST_DONE_WITH_SEND: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (state_o == 1'b1)); // R3

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(state_o == 1'b0 && valid && ready) |=> $stable(data_out)); // R8

    AST_NO_EARLY_MOVE: assert property (@(posedge clk) disable iff (rst)
        (!valid || !ready) |=> !tx_done); // R1

endmodule

bind hsx_tx_stage hsx_tx_stage_chk #(
    .WORD_W (WORD_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .valid    (valid),
    .ready    (ready),
    .data_in  (data_in),
    .data_out (data_out),
    .tx_done  (tx_done),
    .state_o  (state_o)
);

// File: tb/hsx_tx_stage_bench.sv
`timescale 1ns/1ps
module hsx_tx_stage_bench;

    localparam int unsigned W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid = 1'b0;
    logic         ready = 1'b0;
    logic [W-1:0] data_in = '0;
    logic [W-1:0] data_out;
    logic         tx_done;
    logic         state_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    hsx_tx_stage #(.WORD_W(W)) u_hsx_tx_stage (
        .clk      (clk),
        .rst      (rst),
        .valid    (valid),
        .ready    (ready),
        .data_in  (data_in),
        .data_out (data_out),
        .tx_done  (tx_done),
        .state_o  (state_o)
    );

    typedef struct {
        logic [W-1:0] exp_data;
        logic         exp_done;
        logic         exp_state;
        string        tag;
    } item_t;

    item_t sb_q[$];

    // Bench model of the outputs after the next edge.
    logic         m_state = 1'b0;
    logic [W-1:0] m_data  = '0;

    task automatic check1(input string tag, input string what,
                          input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, pushes what must appear after the edge.
    task automatic drive(input logic v, input logic r, input logic [W-1:0] d,
                         input string tag);
        item_t it;
        logic  take;
        @(negedge clk);
        rst     = 1'b0;
        valid   = v;
        ready   = r;
        data_in = d;
        take    = (m_state == 1'b0) && v && r;
        if (take) m_data = d;
        m_state      = take;
        it.exp_data  = m_data;
        it.exp_done  = take;
        it.exp_state = take;
        it.tag       = tag;
        sb_q.push_back(it);
    endtask

    task automatic do_reset(input logic v, input logic r, input logic [W-1:0] d);
        item_t it;
        @(negedge clk);
        rst     = 1'b1;
        valid   = v;
        ready   = r;
        data_in = d;
        m_state = 1'b0;
        m_data  = '0;
        it.exp_data  = '0;
        it.exp_done  = 1'b0;
        it.exp_state = 1'b0;
        it.tag       = "R4";
        sb_q.push_back(it);
    endtask

    // Monitor: compares every cycle after the edge settles.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check1(it.tag, "data_out", data_out, it.exp_data);
                check1(it.tag, "tx_done", {{(W-1){1'b0}}, tx_done}, {{(W-1){1'b0}}, it.exp_done});
                check1(it.tag, "state_o", {{(W-1){1'b0}}, state_o}, {{(W-1){1'b0}}, it.exp_state});
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R4: reset with a handshake present must still clear everything
        do_reset(1'b1, 1'b1, 64'hDEAD_BEEF_0000_1111);
        do_reset(1'b1, 1'b1, 64'h1234_5678_9ABC_DEF0);

        // R5 / R1: lone valid, lone ready, neither
        drive(1'b1, 1'b0, 64'hAAAA_0000_0000_0001, "R5");
        drive(1'b0, 1'b1, 64'hAAAA_0000_0000_0002, "R1");
        drive(1'b0, 1'b0, 64'hAAAA_0000_0000_0003, "R5");

        // R6 / R2 / R3: single handshake then idle
        drive(1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
        drive(1'b0, 1'b0, 64'h0, "R3");
        drive(1'b1, 1'b0, 64'h5555_5555_5555_5555, "R8");
        drive(1'b1, 1'b1, 64'h8000_0000_0000_0001, "R2");

        // R7: handshake held; accepted only on alternate cycles
        drive(1'b1, 1'b1, 64'h0BAD_0BAD_0BAD_0BAD, "R7");
        drive(1'b1, 1'b1, 64'h0102_0304_0506_0708, "R6");
        drive(1'b1, 1'b1, 64'h1111_2222_3333_4444, "R7");
        drive(1'b1, 1'b1, 64'h0000_0000_0000_0000, "R2");
        drive(1'b1, 1'b1, 64'h7777_7777_7777_7777, "R7");

        // R8: hold across long idle with changing data_in
        for (int i = 0; i < 6; i++) begin
            drive(1'b0, 1'b1, {$urandom, $urandom}, "R8");
        end

        // R4: reset mid-run clears a held word
        do_reset(1'b0, 1'b0, 64'h0);
        drive(1'b0, 1'b0, 64'hCAFE_CAFE_CAFE_CAFE, "R8");

        // Mixed patterns
        for (int i = 0; i < 300; i++) begin
            logic v;
            logic r;
            v = ($urandom % 4) != 0;
            r = ($urandom % 3) != 0;
            drive(v, r, {$urandom, $urandom}, "R1");
        end

        drive(1'b0, 1'b0, 64'h0, "R8");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule